// File: doc/BRIEF.md
# Nibble Accumulator AND Executor

This block is the decode and execute slice of a 4-bit accumulator machine that handles the AND-into-accumulator instruction family. It accepts 10-bit instruction words from a fetch port and supports three operand sources:

- a register operand, taken from a 32-entry file of 4-bit registers arranged as two banks of sixteen;
- an immediate operand, carried in the second word of a two-word instruction;
- an indirect operand, read as one nibble of a 10-bit program-memory word.

The indirect memory address is built from a page register followed by the contents of two fixed registers.

Sibling slices of the machine load the register file, the accumulator, the page register and the carry flag through a single write port. Program memory sits outside the block. It answers a read one clock after the address is presented, so an indirect AND completes on the clock after its fetch. The instruction fetched in that next cycle may itself be an AND, and both results are merged into the accumulator in that same cycle.

Top module: `nae_top`

## Requirements
- R1: After reset the accumulator, carry, page register, all 32 registers and the pending-immediate state are zero, and `pmem_rd` is low.
- R2: A fetched word with bits 9:6 = 1101 and bit 4 = 0 ANDs the accumulator with register {bit 5, bits 3:0}, where bit 5 is the bank. The result is visible after the fetch clock edge.
- R3: The word 1101110001 ANDs nothing. The next valid fetched word is taken as data and is never decoded as an opcode, and no memory read is issued for it. Its bits 3:0 are ANDed into the accumulator and its bits 9:4 are ignored.
- R4: A word of the form 1101 s 10000 raises `pmem_rd` in its fetch cycle. It presents `pmem_addr` = {page, register 16, register 0}, with register 16 (bank 1, entry 0) as the middle nibble and register 0 as the low nibble.
- R5: One clock after an indirect fetch, the accumulator is ANDed with bits 7:4 of `pmem_data` when s = 0, or with bits 3:0 when s = 1. Bits 9:8 never take part.
- R6: Any other word, and any cycle with `fetch_valid` low, leaves the accumulator unchanged and issues no read. A pending immediate survives idle cycles.
- R7: No AND form changes the carry flag or any register. Only the write port changes them.
- R8: When an indirect completes in the same cycle that another AND is fetched, the accumulator becomes old value AND memory nibble AND the new operand.
- R9: Write port: `ext_wr_sel` 0 writes register `ext_wr_idx`, 1 writes the accumulator, 2 writes the page register, and 3 writes `ext_wr_data[0]` to the carry flag. A write to the accumulator overrides any AND result in the same cycle.
- R10: A register write in the same cycle as a register-form AND or an indirect fetch takes effect after it. The AND and the address use the old register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Instruction word present this cycle |
| fetch_word | input | 10 | Fetched instruction word |
| pmem_rd | output | 1 | Program-memory read request |
| pmem_addr | output | 12 | Program-memory address {page, reg16, reg0} |
| pmem_data | input | 10 | Program-memory read data, one clock after the address |
| ext_wr_en | input | 1 | State write enable from sibling slices |
| ext_wr_sel | input | 2 | Write target: 0 register, 1 accumulator, 2 page, 3 carry |
| ext_wr_idx | input | 5 | Register index for target 0 |
| ext_wr_data | input | 4 | Write data |
| acc | output | 4 | Accumulator |
| carry | output | 1 | Carry flag |

## Verification
The completion of an indirect AND and the execution of the next fetched AND fall in the same cycle. The bench provokes this by issuing back-to-back indirect fetches, and an indirect fetch followed directly by register and immediate forms. It judges each case against a bench-side model that applies the memory nibble first and the new operand second. A write-port accumulator load is also placed on a completion cycle, and its value must win. A register write is placed on the cycle of an indirect fetch, and the address must still use the old register value.

// File: rtl/nae_pkg.sv
`timescale 1ns/1ps
package nae_pkg;

  typedef enum logic [1:0] {
    TGT_REG   = 2'd0,
    TGT_ACC   = 2'd1,
    TGT_PAGE  = 2'd2,
    TGT_CARRY = 2'd3
  } wr_tgt_e;

  localparam logic [3:0] OPC_AND      = 4'b1101;
  localparam logic [4:0] IND_TAIL     = 5'b10000;
  localparam logic [5:0] IMM_HEAD_LOW = 6'b110001;

  typedef struct packed {
    logic use_reg;
    logic use_imm;
    logic start_ind;
    logic start_pend;
    logic low_nib;
  } dec_t;

endpackage

// File: rtl/nae_decode.sv
`timescale 1ns/1ps
module nae_decode
  import nae_pkg::*;
(
  input  logic       valid,
  input  logic [9:0] word,
  input  logic       pend,
  output dec_t       dec
);

  always_comb begin
    dec = '0;
    dec.low_nib = word[5];
    if (valid) begin
      if (pend) begin
        dec.use_imm = 1'b1;
      end else if (word[9:6] == OPC_AND) begin
        if (!word[4]) begin
          dec.use_reg = 1'b1;
        end else if (word[4:0] == IND_TAIL) begin
          dec.start_ind = 1'b1;
        end else if (word[5:0] == IMM_HEAD_LOW) begin
          dec.start_pend = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/nae_regfile.sv
`timescale 1ns/1ps
module nae_regfile #(
  parameter int W     = 4,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  ptr_hi,
  output logic [W-1:0]  ptr_lo
);

  logic [W-1:0] q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic         en;
    logic [W-1:0] d;

    always_comb begin
      en = wr_en && (wr_addr == AW'(i));
      d  = en ? wr_data : q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= '0;
      else        q[i] <= d;
    end
  end

  assign rd_data = q[rd_addr];
  assign ptr_hi  = q[DEPTH/2];
  assign ptr_lo  = q[0];

  // R7: without a write the operand read at an address is unchanged next cycle
  a_r7_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (rd_data == $past(rd_data)) || (rd_addr != $past(rd_addr)));

endmodule

// File: rtl/nae_acc.sv
`timescale 1ns/1ps
module nae_acc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mem_en,
  input  logic [W-1:0] mem_nib,
  input  logic         op_en,
  input  logic [W-1:0] op_nib,
  input  logic         ext_en,
  input  logic [W-1:0] ext_nib,
  output logic [W-1:0] acc_q
);

  logic [W-1:0] mask;
  logic [W-1:0] acc_d;

  always_comb begin
    mask = '1;
    if (mem_en) mask = mask & mem_nib;
    if (op_en)  mask = mask & op_nib;
    acc_d = ext_en ? ext_nib : (acc_q & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // R2: an AND can only clear accumulator bits, never set them
  a_r2_and_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en) |=> ((acc_q & ~$past(acc_q)) == '0));

  // R9: a write-port load takes the written value regardless of operands
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |=> (acc_q == $past(ext_nib)));

endmodule

// File: rtl/nae_top.sv
`timescale 1ns/1ps
module nae_top
  import nae_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 10,
  parameter int PAGE_W = 4,
  parameter int NREG   = 32,
  localparam int RA_W   = $clog2(NREG),
  localparam int ADDR_W = PAGE_W + 2*NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [WORD_W-1:0] fetch_word,
  output logic              pmem_rd,
  output logic [ADDR_W-1:0] pmem_addr,
  input  logic [WORD_W-1:0] pmem_data,
  input  logic              ext_wr_en,
  input  logic [1:0]        ext_wr_sel,
  input  logic [RA_W-1:0]   ext_wr_idx,
  input  logic [NIB_W-1:0]  ext_wr_data,
  output logic [NIB_W-1:0]  acc,
  output logic              carry
);

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  wr_tgt_e tgt;
  assign tgt = wr_tgt_e'(ext_wr_sel);

  logic wr_reg, wr_acc, wr_page, wr_carry;
  always_comb begin
    wr_reg   = ext_wr_en && (tgt == TGT_REG);
    wr_acc   = ext_wr_en && (tgt == TGT_ACC);
    wr_page  = ext_wr_en && (tgt == TGT_PAGE);
    wr_carry = ext_wr_en && (tgt == TGT_CARRY);
  end

  // decode
  logic pend_q;
  dec_t dec;

  nae_decode u_dec (
    .valid (fetch_valid),
    .word  (fetch_word),
    .pend  (pend_q),
    .dec   (dec)
  );

  // register file
  logic [NIB_W-1:0] rd_nib, ptr_hi, ptr_lo;

  nae_regfile #(.W(NIB_W), .DEPTH(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .wr_en   (wr_reg),
    .wr_addr (ext_wr_idx),
    .wr_data (ext_wr_data),
    .rd_addr ({fetch_word[5], fetch_word[3:0]}),
    .rd_data (rd_nib),
    .ptr_hi  (ptr_hi),
    .ptr_lo  (ptr_lo)
  );

  // control state
  logic              ind_q, ind_d;
  logic              low_q, low_d;
  logic              pend_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              carry_q, carry_d;

  always_comb begin
    ind_d   = dec.start_ind;
    low_d   = dec.start_ind ? dec.low_nib : low_q;
    pend_d  = fetch_valid ? dec.start_pend : pend_q;
    page_d  = wr_page ? ext_wr_data[PAGE_W-1:0] : page_q;
    carry_d = wr_carry ? ext_wr_data[0] : carry_q;
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      ind_q   <= 1'b0;
      low_q   <= 1'b0;
      pend_q  <= 1'b0;
      page_q  <= '0;
      carry_q <= 1'b0;
    end else begin
      ind_q   <= ind_d;
      low_q   <= low_d;
      pend_q  <= pend_d;
      page_q  <= page_d;
      carry_q <= carry_d;
    end
  end

  // memory port
  assign pmem_rd   = dec.start_ind;
  assign pmem_addr = {page_q, ptr_hi, ptr_lo};

  logic [NIB_W-1:0] mem_nib;
  logic [1:0]       unused_top_bits;
  assign mem_nib = low_q ? pmem_data[NIB_W-1:0] : pmem_data[2*NIB_W-1:NIB_W];
  assign unused_top_bits = pmem_data[WORD_W-1:2*NIB_W];

  // accumulator
  logic [NIB_W-1:0] op_nib;
  assign op_nib = dec.use_reg ? rd_nib : fetch_word[NIB_W-1:0];

  nae_acc #(.W(NIB_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .mem_en  (ind_q),
    .mem_nib (mem_nib),
    .op_en   (dec.use_reg | dec.use_imm),
    .op_nib  (op_nib),
    .ext_en  (wr_acc),
    .ext_nib (ext_wr_data),
    .acc_q   (acc)
  );

  assign carry = carry_q;

  // R3: the word after an immediate head never starts a memory read
  a_r3_data_not_decoded: assert property (@(posedge clk) disable iff (!rst_s_q)
    pend_q |-> !pmem_rd);

  // R6: a read is only requested for a presented word
  a_r6_rd_needs_fetch: assert property (@(posedge clk) disable iff (!rst_s_q)
    pmem_rd |-> fetch_valid);

  // R2: decode picks at most one action per word
  a_r2_single_action: assert property (@(posedge clk) disable iff (!rst_s_q)
    $onehot0({dec.use_reg, dec.use_imm, dec.start_ind, dec.start_pend}));

  // R7: the carry changes only through the write port
  a_r7_carry_hold: assert property (@(posedge clk) disable iff (!rst_s_q)
    !(ext_wr_en && ext_wr_sel == 2'd3) |=> $stable(carry));

  // R6: with nothing fetched, nothing in flight and no load, the accumulator holds
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_s_q)
    (!fetch_valid && !ind_q && !(ext_wr_en && ext_wr_sel == 2'd1)) |=> $stable(acc));

endmodule

// File: tb/nae_top_test.sv
`timescale 1ns/1ps
module nae_top_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [9:0]  fetch_word;
  logic        pmem_rd;
  logic [11:0] pmem_addr;
  logic [9:0]  pmem_data;
  logic        ext_wr_en;
  logic [1:0]  ext_wr_sel;
  logic [4:0]  ext_wr_idx;
  logic [3:0]  ext_wr_data;
  logic [3:0]  acc;
  logic        carry;

  always #10 clk = ~clk;

  nae_top uut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .pmem_rd(pmem_rd), .pmem_addr(pmem_addr), .pmem_data(pmem_data),
    .ext_wr_en(ext_wr_en), .ext_wr_sel(ext_wr_sel), .ext_wr_idx(ext_wr_idx),
    .ext_wr_data(ext_wr_data), .acc(acc), .carry(carry)
  );

  // program memory model: registered read
  logic [9:0] mem [4096];
  initial for (int i = 0; i < 4096; i++) mem[i] = 10'((i * 37 + 5) ^ (i >> 3));
  always @(posedge clk) pmem_data <= mem[pmem_addr];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         due;
    logic [3:0] acc;
    logic       c;
    string      tag;
  } item_t;
  item_t sb[$];
  item_t mon_it;

  // bench model state
  logic [3:0] m_acc, m_page, m_nib;
  logic       m_c, m_pend, m_ind;
  logic [3:0] m_regs [32];

  task automatic report(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      mon_it = sb.pop_front();
      report({mon_it.tag, " acc"}, 16'(acc), 16'(mon_it.acc));
      report({mon_it.tag, " carry (R7)"}, 16'(carry), 16'(mon_it.c));
    end
  end

  // driver: one cycle of stimulus with its expected outcome
  task automatic step(input logic v, input logic [9:0] w, input logic we,
                      input logic [1:0] ws, input logic [4:0] wa,
                      input logic [3:0] wd, input string tag);
    logic [3:0]  a;
    logic        ind_n, pend_n;
    logic [11:0] ad;
    item_t       it;
    @(negedge clk);
    fetch_valid = v; fetch_word = w;
    ext_wr_en = we; ext_wr_sel = ws; ext_wr_idx = wa; ext_wr_data = wd;
    #1;
    a = m_acc;
    if (m_ind) a = a & m_nib;
    ind_n = 1'b0;
    pend_n = m_pend;
    if (v) begin
      pend_n = 1'b0;
      if (m_pend) a = a & w[3:0];
      else if (w[9:6] == 4'b1101 && !w[4]) a = a & m_regs[{w[5], w[3:0]}];
      else if (w[9:6] == 4'b1101 && w[4:0] == 5'b10000) begin
        ind_n = 1'b1;
        ad = {m_page, m_regs[16], m_regs[0]};
        m_nib = w[5] ? mem[ad][3:0] : mem[ad][7:4];
        report({tag, " addr R4"}, 16'(pmem_addr), 16'(ad));
      end else if (w == 10'b1101110001) pend_n = 1'b1;
    end
    report({tag, " rd R4/R6/R3"}, 16'(pmem_rd), 16'(ind_n));
    if (we) begin
      case (ws)
        2'd0: m_regs[wa] = wd;
        2'd1: a = wd;
        2'd2: m_page = wd;
        default: m_c = wd[0];
      endcase
    end
    m_acc = a; m_ind = ind_n; m_pend = pend_n;
    it.due = cyc + 1; it.acc = a; it.c = m_c; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic ins(input logic [9:0] w, input string tag);
    step(1'b1, w, 1'b0, 2'd0, 5'd0, 4'd0, tag);
  endtask
  task automatic wr(input logic [1:0] s, input logic [4:0] a, input logic [3:0] d, input string tag);
    step(1'b0, 10'd0, 1'b1, s, a, d, tag);
  endtask
  task automatic idle(input string tag);
    step(1'b0, 10'd0, 1'b0, 2'd0, 5'd0, 4'd0, tag);
  endtask

  // watchdog
  initial begin
    while (cyc < 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_valid = 1'b0; fetch_word = '0;
    ext_wr_en = 1'b0; ext_wr_sel = '0; ext_wr_idx = '0; ext_wr_data = '0;
    m_acc = '0; m_page = '0; m_nib = '0; m_c = 1'b0; m_pend = 1'b0; m_ind = 1'b0;
    for (int i = 0; i < 32; i++) m_regs[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    report("R1 reset acc", 16'(acc), 16'h0);
    report("R1 reset carry", 16'(carry), 16'h0);
    report("R1 reset rd", 16'(pmem_rd), 16'h0);

    // R1: registers reset to zero, pending clear
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101_0_0_0101, "R1 reg5 reset zero");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101_1_0_0000, "R1 reg16 reset zero");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b0000000101, "R1 no pending after reset");

    // load register file, page, carry
    for (int i = 0; i < 32; i++) wr(2'd0, 5'(i), 4'((i * 7 + 3) & 15), "R9 load reg");
    wr(2'd2, 5'd0, 4'hA, "R9 load page");
    wr(2'd3, 5'd0, 4'h1, "R9 load carry");

    // R2: register forms across both banks
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101_0_0_0011, "R2 bank0 reg3");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101_1_0_1110, "R2 bank1 reg14");
    ins(10'b1101_0_0_0001, "R2 chained reg1");

    // R3: immediate, upper bits of data ignored
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101110001, "R3 imm head");
    ins(10'b1111110110, "R3 imm data 6");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101110001, "R3 imm head");
    idle("R6 idle keeps pending");
    idle("R6 idle keeps pending");
    ins(10'b1101010000, "R3 data looks indirect");
    ins(10'b1101110001, "R3 imm head");
    ins(10'b1101110001, "R3 data looks like head");
    ins(10'b1101_0_0_0000, "R3 decoding resumes");

    // R4/R5: indirect, both nibbles
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101010000, "R5 indirect upper");
    idle("R5 upper applied");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101110000, "R5 indirect lower");
    idle("R5 lower applied");
    wr(2'd0, 5'd0, 4'h7, "R4 change reg0");
    wr(2'd0, 5'd16, 4'hC, "R4 change reg16");
    wr(2'd2, 5'd0, 4'h3, "R4 change page");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101110000, "R4 new address");

    // R8: completion overlapping next AND
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101010000, "R8 ind then ind");
    ins(10'b1101110000, "R8 ind overlapping ind");
    ins(10'b1101_1_0_0101, "R8 ind overlapping reg");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101110000, "R8 ind then imm head");
    ins(10'b1101110001, "R8 head overlapping ind");
    ins(10'b0000001011, "R8 imm data");

    // R9: load overrides completing indirect
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    ins(10'b1101010000, "R9 ind before load");
    wr(2'd1, 5'd0, 4'h9, "R9 load wins over completion");

    // R10: register write same cycle as use
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    step(1'b1, 10'b1101_0_0_0010, 1'b1, 2'd0, 5'd2, 4'h0, "R10 reg AND uses old value");
    ins(10'b1101_0_0_0010, "R10 new value visible");
    wr(2'd1, 5'd0, 4'hF, "R9 load acc");
    step(1'b1, 10'b1101010000, 1'b1, 2'd0, 5'd0, 4'h1, "R10 addr uses old reg0");
    idle("R10 indirect applied");

    // R6: unrecognised words and idle
    wr(2'd1, 5'd0, 4'hB, "R9 load acc");
    ins(10'b0000000000, "R6 nop zero");
    ins(10'b1101010001, "R6 nop 1101010001");
    ins(10'b1101111111, "R6 nop 1101111111");
    ins(10'b1001000000, "R6 nop other opcode");
    idle("R6 idle");
    wr(2'd3, 5'd0, 4'h0, "R7 clear carry");
    ins(10'b1101_0_0_0100, "R7 carry stays after AND");

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule